// File: doc/BRIEF.md
# Write-Through Single-Word Associative Cache

This block sits between a processor request port and a slower main-memory port. It holds a small number of entries. Each entry has a valid flag, the full word address as its tag, and one data word. Any address may be placed in any entry. When a read matches a valid entry, the stored word is returned quickly and memory is not touched. When a read finds no match, the word is fetched from memory. It is then placed in a chosen entry and handed back to the processor.

Every write goes out to memory, whether or not the address is cached. The cache copy is refreshed on a match. When there is no match, the cache copy is created directly from the write data, with no memory read. The block keeps only one request in flight. While a memory access is outstanding, the processor side is held off.

Top module: `wt_word_cache`

## Requirements
- R1: After reset every entry is invalid, `cpu_ready` is 1, and `cpu_resp_valid` and `mem_req_valid` are 0. The first read of any address is therefore a miss.
- R2: A read whose address matches a valid entry returns the stored word on `cpu_resp_rdata`, with `cpu_resp_valid` high, in the cycle after acceptance. No memory request is issued for it.
- R3: A read that matches no entry issues exactly one memory read of that address. It responds with the memory word in the cycle after `mem_resp_valid`, and installs the word so that a later read of the same address hits.
- R4: Every accepted write issues one memory write (`mem_req_we`=1) carrying the processor address and data, on a hit and on a miss alike. `cpu_resp_valid` rises in the cycle after memory acknowledges the write with `mem_resp_valid`.
- R5: A write that hits replaces the cached word, and a following read hit returns the new value.
- R6: A write that misses allocates an entry filled from the write data and performs no memory read. A following read of that address hits.
- R7: Victim choice works as follows. The lowest-numbered invalid entry is used if one exists. Otherwise the entry named by a rotating pointer is used. The pointer starts at 0 after reset and advances by one, wrapping, on every allocation (read-miss install or write miss).
- R8: `cpu_ready` is 0 from the acceptance of a request that needs memory until its response, so only one request is in flight.
- R9: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays valid and its address, data and direction hold steady.
- R10: No two valid entries ever hold the same tag. Repeated writes to one address leave only the newest value visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request valid |
| cpu_ready | output | 1 | Cache can accept a request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_rdata | output | DATA_W | Read data (write data echoed for writes) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | Memory request is a write |
| mem_req_addr | output | ADDR_W | Memory word address |
| mem_req_wdata | output | DATA_W | Memory write data |
| mem_resp_valid | input | 1 | Memory read data or write acknowledge |
| mem_resp_rdata | input | DATA_W | Memory read data |

## Verification
The function is driven with a directed series first: a cold miss, a repeat hit, a write hit, a write miss, then a fill of every entry followed by misses that force eviction. Together these separate the hit path from the miss path and show which entry the rotating pointer removes. The same checks then run under several memory stall and response latencies. This shows that hit timing does not depend on memory timing, and that the request stays stable while stalled. A long pseudo-random mix of reads and writes over an address set twice the cache size then stresses replacement order against a behavioural model.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } wtc_state_e;
endpackage

// File: rtl/wtc_lookup.sv
module wtc_lookup #(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0]             valid_i,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] tag_i,
    input  logic [ADDR_W-1:0]              addr_i,
    output logic [ENTRIES-1:0]             match_o,
    output logic                           hit_o,
    output logic [IDX_W-1:0]               idx_o
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_o[g] = valid_i[g] && (tag_i[g] == addr_i);
    end

    always_comb begin
        idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_o[i]) idx_o = IDX_W'(i);
        end
    end

    assign hit_o = |match_o;
endmodule

// File: rtl/wtc_victim.sv
module wtc_victim #(
    parameter int ENTRIES = 4,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_i,
    input  logic               alloc_i,
    output logic [IDX_W-1:0]   victim_o
);
    logic [IDX_W-1:0] ptr_d, ptr_q;
    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_i[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
        victim_o = any_free ? free_idx : ptr_q;
        ptr_d    = ptr_q;
        if (alloc_i) begin
            ptr_d = (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    // R7: an invalid entry is always taken before any valid one
    a_r7_prefer_free: assert property (@(posedge clk) disable iff (!rst_n)
        !(&valid_i) |-> !valid_i[victim_o]);
endmodule

// File: rtl/wt_word_cache.sv
module wt_word_cache
    import wtc_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    output logic              cpu_ready,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_resp_valid,
    output logic [DATA_W-1:0] cpu_resp_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_resp_valid,
    input  logic [DATA_W-1:0] mem_resp_rdata
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        wtc_state_e                     state;
        logic [ENTRIES-1:0]             valid;
        logic [ENTRIES-1:0][ADDR_W-1:0] tag;
        logic [ENTRIES-1:0][DATA_W-1:0] data;
        logic                           mreq;
        logic                           mwe;
        logic [ADDR_W-1:0]              maddr;
        logic [DATA_W-1:0]              mwdata;
        logic                           rvalid;
        logic [DATA_W-1:0]              rdata;
    } cache_st_t;

    cache_st_t        st_d, st_q;
    logic [ENTRIES-1:0] lk_match;
    logic               lk_hit;
    logic [IDX_W-1:0]   lk_idx;
    logic [IDX_W-1:0]   vic_idx;
    logic               alloc;

    wtc_lookup #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_lookup (
        .valid_i (st_q.valid),
        .tag_i   (st_q.tag),
        .addr_i  (cpu_addr),
        .match_o (lk_match),
        .hit_o   (lk_hit),
        .idx_o   (lk_idx)
    );

    wtc_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (st_q.valid),
        .alloc_i  (alloc),
        .victim_o (vic_idx)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        alloc       = 1'b0;
        unique case (st_q.state)
            ST_IDLE: begin
                if (cpu_valid) begin
                    if (!cpu_we && lk_hit) begin
                        st_d.rvalid = 1'b1;
                        st_d.rdata  = st_q.data[lk_idx];
                    end else begin
                        st_d.mreq   = 1'b1;
                        st_d.mwe    = cpu_we;
                        st_d.maddr  = cpu_addr;
                        st_d.mwdata = cpu_wdata;
                        st_d.state  = ST_REQ;
                        if (cpu_we) begin
                            if (lk_hit) begin
                                st_d.data[lk_idx] = cpu_wdata;
                            end else begin
                                alloc                = 1'b1;
                                st_d.valid[vic_idx]  = 1'b1;
                                st_d.tag[vic_idx]    = cpu_addr;
                                st_d.data[vic_idx]   = cpu_wdata;
                            end
                        end
                    end
                end
            end
            ST_REQ: begin
                if (mem_req_ready) begin
                    st_d.mreq  = 1'b0;
                    st_d.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_resp_valid) begin
                    st_d.state  = ST_IDLE;
                    st_d.rvalid = 1'b1;
                    if (st_q.mwe) begin
                        st_d.rdata = st_q.mwdata;
                    end else begin
                        st_d.rdata          = mem_resp_rdata;
                        alloc               = 1'b1;
                        st_d.valid[vic_idx] = 1'b1;
                        st_d.tag[vic_idx]   = st_q.maddr;
                        st_d.data[vic_idx]  = mem_resp_rdata;
                    end
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cpu_ready      = (st_q.state == ST_IDLE);
    assign cpu_resp_valid = st_q.rvalid;
    assign cpu_resp_rdata = st_q.rdata;
    assign mem_req_valid  = st_q.mreq;
    assign mem_req_we     = st_q.mwe;
    assign mem_req_addr   = st_q.maddr;
    assign mem_req_wdata  = st_q.mwdata;

    // R2: a hit read answers in the next cycle without going to memory
    a_r2_hit_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_ready && !cpu_we && lk_hit) |=> (cpu_resp_valid && !mem_req_valid));

    // R4: every accepted write goes out to memory with its address
    a_r4_write_through: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_ready && cpu_we) |=>
        (mem_req_valid && mem_req_we && mem_req_addr == $past(cpu_addr)));

    // R8: the processor side is closed while memory is being used
    a_r8_single_flight: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !cpu_ready);

    // R9: a stalled memory request holds still
    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
        (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wdata) && $stable(mem_req_we)));

    // R10: tags stay unique, so at most one entry matches
    a_r10_unique_tag: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));
endmodule

// File: tb/wt_word_cache_tb_top.sv
`timescale 1ns/1ps
module wt_word_cache_tb_top;
    localparam int ENTRIES = 4;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic              cpu_valid = 1'b0, cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic              cpu_ready, cpu_resp_valid;
    logic [DATA_W-1:0] cpu_resp_rdata;
    logic              mem_req_valid, mem_req_we;
    logic [ADDR_W-1:0] mem_req_addr;
    logic [DATA_W-1:0] mem_req_wdata;
    logic              mem_req_ready = 1'b0, mem_resp_valid = 1'b0;
    logic [DATA_W-1:0] mem_resp_rdata = '0;

    wt_word_cache #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_resp_valid(cpu_resp_valid), .cpu_resp_rdata(cpu_resp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata),
        .mem_resp_valid(mem_resp_valid), .mem_resp_rdata(mem_resp_rdata)
    );

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    task automatic check(bit ok, string req, longint act, longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ---------------- main memory model ----------------
    logic [DATA_W-1:0] bmem [int];
    int rdy_delay = 0, resp_lat = 1;
    int n_rd = 0, n_wr = 0;
    bit pend = 0, pend_we = 0;
    int pend_cnt = 0, stall_cnt = 0;
    logic [ADDR_W-1:0] pend_addr;

    function automatic logic [DATA_W-1:0] mem_word(int a);
        if (bmem.exists(a)) return bmem[a];
        return DATA_W'(a * 40503 + 32'h1357);
    endfunction

    always @(posedge clk) begin
        if (mem_req_valid && mem_req_ready) begin
            pend      = 1;
            pend_we   = mem_req_we;
            pend_addr = mem_req_addr;
            pend_cnt  = resp_lat;
            if (mem_req_we) begin
                bmem[int'(mem_req_addr)] = mem_req_wdata;
                n_wr++;
            end else begin
                n_rd++;
            end
        end
    end

    logic              prev_stall = 0;
    logic [ADDR_W-1:0] prev_addr;
    logic [DATA_W-1:0] prev_wdata;

    always @(negedge clk) begin
        // R9: stalled request must hold its fields
        if (rst_n && prev_stall)
            check(mem_req_valid && mem_req_addr == prev_addr && mem_req_wdata == prev_wdata,
                  "R9", mem_req_addr, prev_addr);
        mem_resp_valid = 0;
        if (pend) begin
            if (pend_cnt == 0) begin
                mem_resp_valid = 1;
                mem_resp_rdata = pend_we ? '0 : mem_word(int'(pend_addr));
                pend = 0;
            end else pend_cnt--;
        end
        if (mem_req_valid && !pend) begin
            if (stall_cnt >= rdy_delay) mem_req_ready = 1;
            else begin mem_req_ready = 0; stall_cnt++; end
        end else begin
            mem_req_ready = 0;
            stall_cnt = 0;
        end
        prev_stall = mem_req_valid && !mem_req_ready;
        prev_addr  = mem_req_addr;
        prev_wdata = mem_req_wdata;
    end

    // ---------------- behavioural cache model ----------------
    int  m_tag [ENTRIES];
    bit  m_val [ENTRIES];
    int  m_ptr = 0;

    function automatic bit m_hit(int a);
        for (int i = 0; i < ENTRIES; i++) if (m_val[i] && m_tag[i] == a) return 1;
        return 0;
    endfunction

    function automatic void m_alloc(int a);
        int v = -1;
        for (int i = 0; i < ENTRIES; i++) if (!m_val[i] && v < 0) v = i;
        if (v < 0) v = m_ptr;
        m_val[v] = 1;
        m_tag[v] = a;
        m_ptr = (m_ptr + 1) % ENTRIES;
    endfunction

    task automatic cpu_op(bit we, int a, logic [DATA_W-1:0] wd, string req);
        bit hit = m_hit(a);
        int rd0, wr0, lat;
        logic [DATA_W-1:0] exp;
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        rd0 = n_rd; wr0 = n_wr;
        exp = we ? wd : mem_word(a);
        cpu_valid = 1; cpu_we = we; cpu_addr = ADDR_W'(a); cpu_wdata = wd;
        @(negedge clk);
        cpu_valid = 0;
        lat = 1;
        if (we || !hit) check(!cpu_ready, {req, "/R8 busy"}, cpu_ready, 0);
        while (!cpu_resp_valid && lat < 500) begin @(negedge clk); lat++; end
        check(cpu_resp_valid, {req, " response"}, cpu_resp_valid, 1);
        if (!we) check(cpu_resp_rdata == exp, {req, " data"}, cpu_resp_rdata, exp);
        if (!we && hit) begin
            check(lat == 1, {req, "/R2 hit latency"}, lat, 1);
            check(n_rd == rd0 && n_wr == wr0, {req, "/R2 no mem"}, n_rd - rd0, 0);
        end else if (!we) begin
            check(n_rd == rd0 + 1, {req, "/R3 one mem read"}, n_rd - rd0, 1);
        end else begin
            check(n_wr == wr0 + 1, {req, "/R4 mem write"}, n_wr - wr0, 1);
            check(n_rd == rd0, {req, "/R6 no mem read"}, n_rd - rd0, 0);
            check(mem_word(a) == wd, {req, "/R4 mem data"}, mem_word(a), wd);
        end
        if (!hit) m_alloc(a);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        int seed = 7;
        for (int i = 0; i < ENTRIES; i++) m_val[i] = 0;
        repeat (3) @(posedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: idle state after reset
        check(cpu_ready && !cpu_resp_valid && !mem_req_valid, "R1 reset outputs",
              {cpu_ready, cpu_resp_valid, mem_req_valid}, 3'b100);

        rdy_delay = 0; resp_lat = 1;
        cpu_op(0, 16'h10, 0, "R1 cold miss");
        cpu_op(0, 16'h10, 0, "R2 repeat hit");
        cpu_op(1, 16'h10, 32'hAAAA_0001, "R5 write hit");
        cpu_op(0, 16'h10, 0, "R5 read new value");
        cpu_op(1, 16'h10, 32'hAAAA_0002, "R10 rewrite");
        cpu_op(0, 16'h10, 0, "R10 newest only");
        cpu_op(1, 16'h20, 32'hBBBB_0003, "R6 write miss");
        cpu_op(0, 16'h20, 0, "R6 read alloc");
        cpu_op(0, 16'h30, 0, "R3 fill");
        cpu_op(0, 16'h40, 0, "R3 fill");
        cpu_op(0, 16'h50, 0, "R7 evict slot0");
        cpu_op(0, 16'h20, 0, "R7 survivor hit");
        cpu_op(0, 16'h10, 0, "R7 evicted miss");
        cpu_op(0, 16'h20, 0, "R7 rotated miss");

        rdy_delay = 3; resp_lat = 4;
        cpu_op(0, 16'h50, 0, "R2 hit slow mem");
        cpu_op(0, 16'h77, 0, "R3 miss slow mem");
        cpu_op(1, 16'h78, 32'hCCCC_0004, "R4 write slow mem");
        rdy_delay = 1; resp_lat = 0;
        cpu_op(1, 16'h77, 32'hDDDD_0005, "R4 write fast mem");
        cpu_op(0, 16'h77, 0, "R5 hit fast mem");

        for (int k = 0; k < 80; k++) begin
            seed = (seed * 1103515245 + 12345) & 32'h7fff_ffff;
            rdy_delay = (seed >> 4) % 3;
            resp_lat  = (seed >> 8) % 3;
            cpu_op(((seed >> 12) % 3) == 0, 16'h100 + ((seed >> 16) % 8),
                   DATA_W'(seed), "R7 mixed");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule